// File: doc/BRIEF.md
# Trace Capture Buffer with Streaming, Ring and Fill-Once Modes

This block sits between an event filter and a trace readout path. Filtered 32-bit trace words arrive on a valid/data port and are kept in a local 256-entry memory. A capture run begins with a start pulse, which latches one of three capture modes. Until the next start, any change on the mode input has no effect.

- In stream mode the memory acts as an elastic queue. Words leave through the read port while capture is still running, so a run can last indefinitely as long as the consumer keeps up.
- In ring mode the memory is a circular store that overwrites its oldest word once full. Capture runs until a stop pulse, and the last 256 words then stay available.
- In fill-once mode capture halts by itself the moment the memory first becomes full.

In both buffered modes the read port stays silent during capture. After capture ends, the read port hands out the stored words oldest first.

A controller state machine has three states:

- IDLE: the state after reset.
- CAPTURE: entered from any state by a start pulse.
- HALTED: entered from CAPTURE by a stop pulse, or by the write that fills memory in fill-once mode.

A start pulse in HALTED or CAPTURE begins a fresh run. The read port is a show-ahead interface: the word is valid with `rd_valid_o`, and it is consumed on a cycle where `rd_req_i` is also high.

Top module: `trace_buf`

## Requirements
- R1: After reset the block is idle: `capture_o`, `done_o`, `wrapped_o` and `rd_valid_o` are 0 and `lost_cnt_o` is 0.
- R2: In stream mode (mode code 0) the read port presents accepted words oldest first, including during capture. A word is removed on each cycle where `rd_valid_o` and `rd_req_i` are both high.
- R3: In stream mode, a write that arrives while 256 words are held and no word is being read out in the same cycle is dropped. That drop raises `lost_cnt_o` by one, and the counter saturates at its maximum.
- R4: In ring mode (mode code 1), a write when the memory is full replaces the oldest word and sets `wrapped_o`. After stop, the 256 most recent words are read oldest first.
- R5: In ring mode, if capture stops before the memory fills, `wrapped_o` stays 0 and readout begins at the first word of the run.
- R6: In fill-once mode (mode code 2), the write that brings the count to 256 ends capture at the next edge. `capture_o` falls and `done_o` rises, and later writes are not stored.
- R7: In ring and fill-once modes `rd_valid_o` stays 0 while capture runs.
- R8: Writes in IDLE or HALTED are ignored, and a stop pulse outside CAPTURE has no effect.
- R9: A start pulse empties the memory and clears `wrapped_o`, `lost_cnt_o` and `done_o`. It takes priority over a stop pulse, a write or a read in the same cycle.
- R10: The mode is sampled only on a start pulse. Mode code 3 behaves as stream mode.
- R11: A stop pulse during CAPTURE ends capture and sets `done_o` in any mode. In stream mode the words still held stay readable afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Capture mode code, sampled at start (0 stream, 1 ring, 2 fill-once, 3 stream) |
| start_i | input | 1 | Begin a fresh capture run |
| stop_i | input | 1 | End the current capture run |
| wr_valid_i | input | 1 | Trace word present |
| wr_data_i | input | 32 | Trace word |
| rd_req_i | input | 1 | Consumer takes the presented word |
| rd_valid_o | output | 1 | A stored word is presented |
| rd_data_o | output | 32 | Oldest stored word |
| capture_o | output | 1 | Capture running (CAPTURE state) |
| done_o | output | 1 | Capture ended by stop or by filling |
| wrapped_o | output | 1 | Ring capture has overwritten data |
| lost_cnt_o | output | 16 | Saturating count of dropped stream words |

## Verification
The assertions take for granted that the inputs are known after reset, and that a start pulse, a stop pulse and a write may land in the same cycle.

The assertions do not assume `rd_req_i` is low during buffered capture; they check that such requests have no effect there. The stimulus deliberately drives requests during ring capture, stop pulses in IDLE and HALTED, writes after a fill-once halt, and mode changes mid-run.

A behavioural queue model predicts every output. It is compared on every clock across directed runs that reach the overflow, wrap and fill edges, and across a long run of mixed random traffic.

// File: rtl/trace_buf_pkg.sv
package trace_buf_pkg;

    typedef enum logic [1:0] {
        MODE_STREAM = 2'd0,
        MODE_RING   = 2'd1,
        MODE_FILL   = 2'd2
    } cap_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_HALTED  = 2'd2
    } cap_state_e;

    function automatic cap_mode_e decode_mode(input logic [1:0] code);
        cap_mode_e m;
        case (code)
            2'd1:    m = MODE_RING;
            2'd2:    m = MODE_FILL;
            default: m = MODE_STREAM;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/trace_buf_ctrl.sv
module trace_buf_ctrl
    import trace_buf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       wr_valid_i,
    input  logic       fill_last_i,
    output cap_mode_e  mode_o,
    output logic       capture_o,
    output logic       done_o,
    output logic       clear_o,
    output logic       accept_o
);

    cap_state_e state_q, state_d;
    cap_mode_e  mode_q;
    logic       done_q;
    logic       fill_end;

    // the accepted write that completes a fill-once run
    assign fill_end = accept_o && (mode_q == MODE_FILL) && fill_last_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                if (start_i)       state_d = ST_CAPTURE;
                else if (stop_i)   state_d = ST_HALTED;
                else if (fill_end) state_d = ST_HALTED;
            end
            ST_HALTED: begin
                if (start_i) state_d = ST_CAPTURE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_STREAM;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                mode_q <= decode_mode(mode_i);
                done_q <= 1'b0;
            end else if ((state_q == ST_CAPTURE) && (state_d == ST_HALTED)) begin
                done_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        capture_o = (state_q == ST_CAPTURE);
        clear_o   = start_i;
        accept_o  = capture_o && wr_valid_i && !start_i && !stop_i;
        done_o    = done_q;
        mode_o    = mode_q;
    end

endmodule

// File: rtl/trace_buf_store.sv
module trace_buf_store
    import trace_buf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  cap_mode_e         mode_i,
    input  logic              capture_i,
    input  logic              rd_req_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              fill_last_o,
    output logic              wrapped_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              drop_o
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0]  LAST_CNT  = CNT_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [ADDR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wrap_q;
    logic              full, pop, store, overwrite, adv_rp;

    function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p);
        return (p == LAST_ADDR) ? '0 : p + 1'b1;
    endfunction

    assign full        = (cnt_q == FULL_CNT);
    assign rd_valid_o  = (cnt_q != '0) && ((mode_i == MODE_STREAM) || !capture_i);
    assign rd_data_o   = mem_q[rp_q];
    assign pop         = rd_valid_o && rd_req_i && !clear_i;
    assign drop_o      = push_i && (mode_i == MODE_STREAM) && full && !pop;
    assign store       = push_i && !drop_o;
    assign overwrite   = store && (mode_i == MODE_RING) && full;
    assign adv_rp      = pop || overwrite;
    assign fill_last_o = (cnt_q == LAST_CNT);
    assign wrapped_o   = wrap_q;
    assign count_o     = cnt_q;

    always_ff @(posedge clk) begin
        if (store) mem_q[wp_q] <= data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            wp_q   <= '0;
            rp_q   <= '0;
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            if (store)  wp_q <= step_ptr(wp_q);
            if (adv_rp) rp_q <= step_ptr(rp_q);
            if (store && !adv_rp)      cnt_q <= cnt_q + 1'b1;
            else if (!store && adv_rp) cnt_q <= cnt_q - 1'b1;
            if (overwrite) wrap_q <= 1'b1;
        end
    end

endmodule

// File: rtl/trace_buf_lost.sv
module trace_buf_lost #(
    parameter int LOST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              drop_i,
    output logic [LOST_W-1:0] lost_o
);

    logic [LOST_W-1:0] lost_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)           lost_q <= '0;
        else if (drop_i && !(&lost_q))   lost_q <= lost_q + 1'b1;
    end

    assign lost_o = lost_q;

endmodule

// File: rtl/trace_buf.sv
module trace_buf
    import trace_buf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    parameter int LOST_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              wr_valid_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_req_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              capture_o,
    output logic              done_o,
    output logic              wrapped_o,
    output logic [LOST_W-1:0] lost_cnt_o
);

    cap_mode_e        mode_q;
    logic             clear, accept, fill_last, drop;
    logic [CNT_W-1:0] fill_cnt;

    trace_buf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .wr_valid_i (wr_valid_i),
        .fill_last_i(fill_last),
        .mode_o     (mode_q),
        .capture_o  (capture_o),
        .done_o     (done_o),
        .clear_o    (clear),
        .accept_o   (accept)
    );

    trace_buf_store #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .push_i     (accept),
        .data_i     (wr_data_i),
        .mode_i     (mode_q),
        .capture_i  (capture_o),
        .rd_req_i   (rd_req_i),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o),
        .fill_last_o(fill_last),
        .wrapped_o  (wrapped_o),
        .count_o    (fill_cnt),
        .drop_o     (drop)
    );

    trace_buf_lost #(
        .LOST_W(LOST_W)
    ) u_lost (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(clear),
        .drop_i (drop),
        .lost_o (lost_cnt_o)
    );

endmodule

// File: rtl/trace_buf_chk.sv
module trace_buf_chk #(
    parameter int DEPTH  = 256,
    parameter int LOST_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              stop_i,
    input logic              wr_valid_i,
    input logic              rd_req_i,
    input logic              rd_valid_o,
    input logic              capture_o,
    input logic              done_o,
    input logic              wrapped_o,
    input logic [LOST_W-1:0] lost_cnt_o,
    input logic [1:0]        mode_q,
    input logic [CNT_W-1:0]  fill_cnt
);

    p_idle_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_o && !done_o) |-> !rd_valid_o);

    p_buf_hidden_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_o && mode_q != 2'd0) |-> !rd_valid_o);

    p_lost_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_cnt_o != $past(lost_cnt_o)) |->
            ((lost_cnt_o == LOST_W'($past(lost_cnt_o) + 1'b1)) || (lost_cnt_o == '0)));

    p_wrap_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrapped_o |-> (mode_q == 2'd1));

    p_fill_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_o && mode_q == 2'd2 && fill_cnt == CNT_W'(DEPTH - 1) &&
         wr_valid_i && !start_i && !stop_i) |=> (done_o && !capture_o));

    p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CNT_W'(DEPTH));

    p_halt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_o && !start_i && !(rd_valid_o && rd_req_i)) |=> $stable(fill_cnt));

    p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (capture_o && !done_o && !wrapped_o && lost_cnt_o == '0 && fill_cnt == '0));

    p_stop_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_o && stop_i && !start_i) |=> (done_o && !capture_o));

endmodule

bind trace_buf trace_buf_chk #(
    .DEPTH (DEPTH),
    .LOST_W(LOST_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .wr_valid_i(wr_valid_i),
    .rd_req_i  (rd_req_i),
    .rd_valid_o(rd_valid_o),
    .capture_o (capture_o),
    .done_o    (done_o),
    .wrapped_o (wrapped_o),
    .lost_cnt_o(lost_cnt_o),
    .mode_q    (mode_q),
    .fill_cnt  (fill_cnt)
);

// File: tb/test_trace_buf.sv
module test_trace_buf;

    localparam int DEPTH = 256;
    localparam int LMAX  = 65535;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode_i;
    logic        start_i, stop_i, wr_valid_i, rd_req_i;
    logic [31:0] wr_data_i;
    logic        rd_valid_o, capture_o, done_o, wrapped_o;
    logic [31:0] rd_data_o;
    logic [15:0] lost_cnt_o;

    always #5 clk = ~clk;

    trace_buf i_trace_buf (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .start_i(start_i),
        .stop_i(stop_i), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
        .rd_req_i(rd_req_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .capture_o(capture_o), .done_o(done_o), .wrapped_o(wrapped_o),
        .lost_cnt_o(lost_cnt_o)
    );

    // reference model state
    logic [31:0] q[$];
    int  m_mode;     // 0 stream, 1 ring, 2 fill-once
    int  m_state;    // 0 idle, 1 capture, 2 halted
    bit  m_done, m_wrap;
    int  m_lost;
    int  n_cmp = 0, n_bad = 0;
    int  cyc = 0;
    bit  finished = 0;
    logic [31:0] seq = 32'h1000_0000;
    string ph = "R1";

    function automatic bit m_valid();
        return (q.size() > 0) && (m_mode == 0 || m_state != 1);
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(ph,    "rd_valid", rd_valid_o, m_valid());
        if (m_valid()) chk(ph, "rd_data", rd_data_o, q[0]);
        chk("R6",  "capture",  capture_o, m_state == 1);
        chk("R11", "done",     done_o, m_done);
        chk("R4",  "wrapped",  wrapped_o, m_wrap);
        chk("R3",  "lost",     lost_cnt_o, m_lost);
    endtask

    // one clock: drive at negedge, advance the model, compare at next negedge
    task automatic tick(input bit st, input bit sp, input logic [1:0] md,
                        input bit wv, input bit rq);
        bit pop;
        start_i = st; stop_i = sp; mode_i = md; wr_valid_i = wv; rd_req_i = rq;
        wr_data_i = seq;
        pop = m_valid() && rq;
        if (st) begin
            q.delete(); m_lost = 0; m_wrap = 0; m_done = 0; m_state = 1;
            m_mode = (md == 2'd1) ? 1 : (md == 2'd2) ? 2 : 0;
        end else begin
            if (pop) void'(q.pop_front());
            if (sp && m_state == 1) begin
                m_state = 2; m_done = 1;
            end else if (m_state == 1 && wv) begin
                if (m_mode == 0) begin
                    if (q.size() == DEPTH) begin
                        if (m_lost < LMAX) m_lost++;
                    end else q.push_back(seq);
                end else if (m_mode == 1) begin
                    if (q.size() == DEPTH) begin
                        void'(q.pop_front()); m_wrap = 1;
                    end
                    q.push_back(seq);
                end else begin
                    q.push_back(seq);
                    if (q.size() == DEPTH) begin m_state = 2; m_done = 1; end
                end
            end
        end
        if (wv) seq++;
        @(negedge clk);
        compare();
    endtask

    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 2'd0, 0, 0);
    endtask

    task automatic drain();
        for (int i = 0; i < DEPTH + 4; i++) tick(0, 0, 2'd0, 0, 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            summary();
        end
    end

    initial begin
        rst_n = 0; start_i = 0; stop_i = 0; mode_i = 0; wr_valid_i = 0;
        rd_req_i = 0; wr_data_i = 0;
        q.delete(); m_mode = 0; m_state = 0; m_done = 0; m_wrap = 0; m_lost = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        ph = "R1"; compare();

        // R8: writes and stop in IDLE are ignored
        ph = "R8";
        for (int i = 0; i < 5; i++) tick(0, i == 2, 2'd1, 1, 1);

        // R2: stream mode, readout during capture
        ph = "R2";
        tick(1, 0, 2'd0, 0, 0);
        for (int i = 0; i < 60; i++) tick(0, 0, 2'd0, ($urandom % 4) != 0, ($urandom % 2) == 0);
        ph = "R11";
        tick(0, 1, 2'd0, 1, 0);
        drain();

        // R3: overflow in stream mode, then accept-on-pop at full
        ph = "R3";
        tick(1, 0, 2'd0, 0, 0);
        for (int i = 0; i < DEPTH + 6; i++) tick(0, 0, 2'd0, 1, 0);
        for (int i = 0; i < 4; i++) tick(0, 0, 2'd0, 1, 1);
        tick(0, 1, 2'd0, 0, 0);
        drain();

        // R4/R7/R10: ring wraps; read requests and mode change mid-run ignored
        ph = "R4";
        tick(1, 0, 2'd1, 0, 0);
        ph = "R7";
        for (int i = 0; i < DEPTH + 45; i++) tick(0, 0, (i > 10) ? 2'd2 : 2'd1, 1, ($urandom % 2) == 0);
        ph = "R4";
        tick(0, 1, 2'd0, 0, 0);
        ph = "R8";
        for (int i = 0; i < 4; i++) tick(0, i == 1, 2'd0, 1, 0);
        ph = "R4";
        for (int i = 0; i < DEPTH + 20; i++) tick(0, 0, 2'd0, 0, ($urandom % 3) != 0);

        // R5: ring stopped before full
        ph = "R5";
        tick(1, 0, 2'd1, 0, 0);
        for (int i = 0; i < 10; i++) tick(0, 0, 2'd1, 1, 1);
        tick(0, 1, 2'd1, 0, 0);
        drain();

        // R6: fill-once halts itself, later writes ignored
        ph = "R6";
        tick(1, 0, 2'd2, 0, 0);
        for (int i = 0; i < DEPTH + 14; i++) tick(0, 0, 2'd2, 1, 1);
        drain();

        // R9: start beats stop and write; restart mid-run; R10: code 3 is stream
        ph = "R9";
        tick(1, 0, 2'd1, 0, 0);
        for (int i = 0; i < 20; i++) tick(0, 0, 2'd1, 1, 0);
        tick(1, 1, 2'd3, 1, 1);
        ph = "R10";
        for (int i = 0; i < 20; i++) tick(0, 0, 2'd1, 1, ($urandom % 2) == 0);
        ph = "R9";
        tick(0, 1, 2'd0, 0, 0);
        tick(1, 0, 2'd0, 0, 1);
        idle_n(3);

        // mixed random traffic
        ph = "R2";
        for (int i = 0; i < 4000; i++)
            tick(($urandom % 300) == 0, ($urandom % 200) == 0, 2'($urandom % 4),
                 ($urandom % 3) != 0, ($urandom % 4) == 0);
        drain();

        summary();
    end

endmodule